// File: doc/BRIEF.md
# Result-Latency Issue Interlock

This block decides, every cycle, whether the single decoded instruction offered to it may enter execution in a single-issue, in-order core. The core has an arithmetic pipe and a load-store pipe, each with execute, memory and write stages. Each offered instruction carries a class code, a destination register with a write flag, and up to three source registers, each with a use bit. Slots 0 and 1 are address or operand sources. Slot 2 is the store-data source.

Two structures make the decision. A scoreboard holds, for every register, a countdown of the cycles left until its pending result can be consumed. A reservation record holds, for each of the six stages, a short window of the cycles in which the stage is already claimed. The block raises `stall` while any used source is still pending, or while the instruction's stage pattern would collide with a claimed stage. When neither applies, `issue` is raised in the same cycle. The offering logic keeps the instruction on the inputs until it issues.

Top module: `issue_interlock`

## Requirements
- R1: After reset no register is pending and no stage is claimed. A valid instruction then issues in the same cycle (`issue`=1, `stall`=0). At all times `issue` = `in_valid` and not `stall`, and `stall` is 0 whenever `in_valid` is 0.
- R2: Class 0 (plain ALU or constant shift; codes 6 and 7 act the same) claims arithmetic execute at offset 0, arithmetic memory at offset 1 and arithmetic write at offset 2, where offset 0 is the issue cycle. A dependent instruction may issue 1 cycle after it.
- R3: Class 1 (shift by register) claims arithmetic execute at offsets 0 and 1, memory at offset 2 and write at offset 3. Its result latency is 2.
- R4: Class 2 (single load) claims arithmetic execute and load-store execute at offset 0, load-store memory at offset 1, and both write stages at offset 2. A dependent instruction waits 2 cycles.
- R5: Classes 3 and 5 (stores) record no result even when the destination write flag is set. They claim the same stages as classes 2 and 4 respectively.
- R6: A class-3 store whose slot-2 source is the destination of a class-2 load may issue 1 cycle after the load. If the load's destination is in slot 0 or slot 1, the store waits the full 2 cycles.
- R7: Class 4 (three- or four-register load) has latency 3. It claims arithmetic execute at offsets 0 to 2, load-store execute at offsets 0 and 1, load-store memory at offsets 1 and 2, and both write stages at offset 3.
- R8: A stalled instruction loads neither the scoreboard nor the reservation record.
- R9: An instruction issues only when its stage pattern overlaps no stage claimed by earlier instructions. Only sources whose use bit is set are checked. A destination is recorded only when its write flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is offered |
| in_class | input | 3 | Instruction class code |
| in_dst | input | REG_W | Destination register |
| in_dst_we | input | 1 | Destination is written |
| in_src0 | input | REG_W | Source slot 0 (address/operand) |
| in_src1 | input | REG_W | Source slot 1 (address/operand) |
| in_src2 | input | REG_W | Source slot 2 (store data/operand) |
| in_src_use | input | 3 | Use bit per source slot |
| stall | output | 1 | Offered instruction must wait |
| issue | output | 1 | Offered instruction enters execution now |

## Verification
A data wait and a stage collision can hold the same instruction at once. Following a shift-by-register or multi-register load with its dependent is the sharpest case, because both waits then end in the same cycle. The bench sweeps every producer class against every consumer class, with the dependence absent, in slot 0, or in slot 2. It counts the stall cycles of the consumer and compares them with the larger of two values computed from the requirements: the latency bound and the first non-colliding offset.

// File: rtl/iil_pkg.sv
package iil_pkg;

  localparam int NUM_UNITS = 6;
  localparam int HORIZON   = 4;
  localparam int CNT_W     = 2;

  localparam int U_AE = 0;
  localparam int U_AM = 1;
  localparam int U_AW = 2;
  localparam int U_LE = 3;
  localparam int U_LM = 4;
  localparam int U_LW = 5;

  typedef enum logic [2:0] {
    C_ALU       = 3'd0,
    C_ALU_SHREG = 3'd1,
    C_LOAD1     = 3'd2,
    C_STORE1    = 3'd3,
    C_LOADM     = 3'd4,
    C_STOREM    = 3'd5
  } iclass_e;

  typedef logic [NUM_UNITS-1:0][HORIZON-1:0] resv_t;

  function automatic resv_t class_resv(logic [2:0] c);
    resv_t r;
    r = '0;
    case (c)
      C_ALU_SHREG: begin
        r[U_AE] = 4'b0011; r[U_AM] = 4'b0100; r[U_AW] = 4'b1000;
      end
      C_LOAD1, C_STORE1: begin
        r[U_AE] = 4'b0001; r[U_LE] = 4'b0001; r[U_LM] = 4'b0010;
        r[U_AW] = 4'b0100; r[U_LW] = 4'b0100;
      end
      C_LOADM, C_STOREM: begin
        r[U_AE] = 4'b0111; r[U_LE] = 4'b0011; r[U_LM] = 4'b0110;
        r[U_AW] = 4'b1000; r[U_LW] = 4'b1000;
      end
      default: begin
        r[U_AE] = 4'b0001; r[U_AM] = 4'b0010; r[U_AW] = 4'b0100;
      end
    endcase
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] class_lat(logic [2:0] c);
    case (c)
      C_ALU_SHREG, C_LOAD1: return 2'd2;
      C_LOADM:              return 2'd3;
      C_STORE1, C_STOREM:   return 2'd0;
      default:              return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/iil_scoreboard.sv
module iil_scoreboard
  import iil_pkg::*;
#(
  parameter int NREG  = 16,
  parameter int REG_W = $clog2(NREG)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [REG_W-1:0]           wr_reg,
  input  logic [CNT_W-1:0]           wr_cnt,
  input  logic                       wr_load,
  input  logic [2:0][REG_W-1:0]      src_reg,
  input  logic [2:0]                 src_use,
  input  logic                       byp_ok,
  output logic                       ready
);

  logic [CNT_W-1:0] cnt       [NREG];
  logic             from_load [NREG];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (rst) begin
        cnt[i]       <= '0;
        from_load[i] <= 1'b0;
      end else if (wr_en && wr_reg == REG_W'(i)) begin
        cnt[i]       <= wr_cnt;
        from_load[i] <= wr_load;
      end else if (cnt[i] != '0) begin
        cnt[i] <= cnt[i] - CNT_W'(1);
      end
    end
  end

  logic [2:0] slot_ok;

  always_comb begin
    for (int s = 0; s < 3; s++) begin
      slot_ok[s] = !src_use[s] || (cnt[src_reg[s]] == '0);
    end
    // store-data bypass from a single load, data slot only
    if (src_use[2] && byp_ok && from_load[src_reg[2]] &&
        cnt[src_reg[2]] == CNT_W'(1))
      slot_ok[2] = 1'b1;
    ready = &slot_ok;
  end

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_chk
      // R2: pending countdowns fall by one each cycle unless reloaded
      p_countdown_r2: assert property (@(posedge clk) disable iff (rst)
        (cnt[g] != '0 && !(wr_en && wr_reg == REG_W'(g)))
          |=> (cnt[g] == $past(cnt[g]) - CNT_W'(1)));
    end
  endgenerate

endmodule

// File: rtl/iil_resv.sv
module iil_resv
  import iil_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       issue,
  input  logic [2:0] cls,
  output logic       free
);

  resv_t busy;
  resv_t req;

  always_comb begin
    req  = class_resv(cls);
    free = 1'b1;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if ((busy[u] & req[u]) != '0) free = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (rst) busy[u] <= '0;
      else     busy[u] <= (busy[u] | (issue ? req[u] : '0)) >> 1;
    end
  end

  generate
    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_chk
      // R9: a claim for the next cycle is held in the record
      p_claim_kept_r9: assert property (@(posedge clk) disable iff (rst)
        (issue && req[g][1]) |=> busy[g][0]);
    end
  endgenerate

endmodule

// File: rtl/issue_interlock.sv
module issue_interlock
  import iil_pkg::*;
#(
  parameter int NREG  = 16,
  parameter int REG_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [2:0]       in_class,
  input  logic [REG_W-1:0] in_dst,
  input  logic             in_dst_we,
  input  logic [REG_W-1:0] in_src0,
  input  logic [REG_W-1:0] in_src1,
  input  logic [REG_W-1:0] in_src2,
  input  logic [2:0]       in_src_use,
  output logic             stall,
  output logic             issue
);

  logic [CNT_W-1:0] lat;
  logic             src_ready;
  logic             stage_free;
  logic             wr_en;

  assign lat   = class_lat(in_class);
  assign stall = in_valid && !(src_ready && stage_free);
  assign issue = in_valid && !stall;
  assign wr_en = issue && in_dst_we && (lat != '0);

  iil_scoreboard #(.NREG(NREG), .REG_W(REG_W)) u_sb (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_reg  (in_dst),
    .wr_cnt  (lat - CNT_W'(1)),
    .wr_load (in_class == C_LOAD1),
    .src_reg ({in_src2, in_src1, in_src0}),
    .src_use (in_src_use),
    .byp_ok  (in_class == C_STORE1),
    .ready   (src_ready)
  );

  iil_resv u_resv (
    .clk   (clk),
    .rst   (rst),
    .issue (issue),
    .cls   (in_class),
    .free  (stage_free)
  );

  // R1: no stall without an offered instruction
  p_idle_no_stall_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> !stall);

  // R4: a consumer of a single load one cycle later must wait
  p_load_use_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(issue && in_class == C_LOAD1 && in_dst_we) && in_valid &&
     in_src_use[0] && in_src0 == $past(in_dst)) |-> stall);

  // R7: multi-register load keeps arithmetic execute for the next cycle
  p_loadm_holds_ae_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(issue && in_class == C_LOADM) && in_valid && in_class == C_ALU)
      |-> stall);

endmodule

// File: tb/tb_issue_interlock.sv
module tb_issue_interlock;

  localparam int CLK_PERIOD = 10;
  localparam int NREG = 16;
  localparam int REG_W = $clog2(NREG);

  logic             clk = 1'b0;
  logic             rst;
  logic             in_valid;
  logic [2:0]       in_class;
  logic [REG_W-1:0] in_dst;
  logic             in_dst_we;
  logic [REG_W-1:0] in_src0, in_src1, in_src2;
  logic [2:0]       in_src_use;
  logic             stall, issue;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  issue_interlock #(.NREG(NREG)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_class(in_class),
    .in_dst(in_dst), .in_dst_we(in_dst_we), .in_src0(in_src0),
    .in_src1(in_src1), .in_src2(in_src2), .in_src_use(in_src_use),
    .stall(stall), .issue(issue)
  );

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // stage masks per class, bit k = offset k (from the requirements)
  function automatic int mask(int c, int u);
    // units: 0 AE 1 AM 2 AW 3 LE 4 LM 5 LW
    case (c)
      1: case (u) 0: return 4'b0011; 1: return 4'b0100; 2: return 4'b1000; default: return 0; endcase
      2, 3: case (u) 0, 3: return 4'b0001; 4: return 4'b0010; 2, 5: return 4'b0100; default: return 0; endcase
      4, 5: case (u) 0: return 4'b0111; 3: return 4'b0011; 4: return 4'b0110; 2, 5: return 4'b1000; default: return 0; endcase
      default: case (u) 0: return 4'b0001; 1: return 4'b0010; 2: return 4'b0100; default: return 0; endcase
    endcase
  endfunction

  function automatic int latency(int c);
    case (c) 1, 2: return 2; 4: return 3; 3, 5: return 0; default: return 1; endcase
  endfunction

  function automatic int expected_delay(int p, int c, int slot);
    int s = 1;
    int dw = 0;
    bit hit = 1'b1;
    while (hit) begin
      hit = 1'b0;
      for (int u = 0; u < 6; u++)
        if (((mask(p, u) >> s) & mask(c, u)) != 0) hit = 1'b1;
      if (hit) s++;
    end
    if (slot != 0 && latency(p) > 0)
      dw = (p == 2 && c == 3 && slot == 2) ? 1 : latency(p);
    return (dw > s) ? dw : s;
  endfunction

  function automatic string tag_of(int p, int c, int slot);
    if (slot == 0) return "R9";
    case (p)
      0: return "R2";
      1: return "R3";
      2: return (c == 3 && slot == 2) ? "R6" : "R4";
      4: return "R7";
      default: return "R5";
    endcase
  endfunction

  task automatic drive(bit v, int cls, int dst, int s0, int s2);
    in_valid = v; in_class = 3'(cls); in_dst = REG_W'(dst); in_dst_we = 1'b1;
    in_src0 = REG_W'(s0); in_src1 = REG_W'(2); in_src2 = REG_W'(s2);
    in_src_use = 3'b111;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 in_valid = 1'b0;
    end
  endtask

  task automatic run_pair(int p, int c, int slot);
    int d;
    idle(6);
    @(posedge clk); #1 drive(1'b1, p, 3, 1, 4);
    @(negedge clk);
    if (stall) $display("producer unexpectedly held class %0d", p);
    @(posedge clk); #1 drive(1'b1, c, 6, (slot == 1) ? 3 : 1, (slot == 2) ? 3 : 4);
    d = 1;
    @(negedge clk);
    while (stall && d < 12) begin
      @(posedge clk); #1;
      d++;
      @(negedge clk);
    end
    @(posedge clk); #1 in_valid = 1'b0;
    check(tag_of(p, c, slot), d, expected_delay(p, c, slot),
          $sformatf("delay prod %0d cons %0d slot %0d", p, c, slot));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1'b1;
    drive(1'b0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    drive(1'b1, 0, 5, 7, 9);
    @(negedge clk);
    check("R1", stall, 0, "stall after reset");
    check("R1", issue, 1, "issue after reset");
    @(posedge clk); #1 in_valid = 1'b0;
    @(negedge clk);
    check("R1", stall, 0, "stall while idle");

    // R8: a held multi-register load must leave no trace
    idle(6);
    @(posedge clk); #1 drive(1'b1, 1, 9, 1, 4);
    @(posedge clk); #1 drive(1'b1, 4, 5, 1, 4);
    @(negedge clk);
    check("R8", stall, 1, "load held behind shift-by-register");
    @(posedge clk); #1 in_valid = 1'b0;
    @(posedge clk); #1 drive(1'b1, 0, 6, 5, 4);
    @(negedge clk);
    check("R8", stall, 0, "reader of held load destination");
    @(posedge clk); #1 in_valid = 1'b0;

    for (int p = 0; p < 6; p++)
      for (int c = 0; c < 6; c++)
        for (int slot = 0; slot < 3; slot++)
          run_pair(p, c, slot);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule